// File: doc/BRIEF.md
# Compound Trace Event Binder

This block watches a stream of trace packets whose type has already been decoded, each with an optional 64-bit address payload. It groups the packets into compound events. An event opens with a source-address packet and closes with a target packet. For each closed event the block reports one record. The record holds the source address, the destination address, and any state-change packets that arrived while the event was open. Those state changes are bound to the destination address, not to the point where they arrived.

Timing packets can arrive at any point, including inside an open event. They go straight out on a pass-through port and do not disturb the pairing. The same port carries branch-outcome packets, and state-change packets that arrive while no event is open. An error output flags two protocol faults: a second source packet before the event closes, and more held state changes than the buffer can keep. The block accepts one packet per clock. Every result appears on the registered outputs one cycle after the packet is accepted.

Top module: `trace_event_binder`

## Requirements
- R1: While `rst_n` is low, `pass_valid`, `ev_valid`, `err_valid` and `in_ready` are all low and no event is open. After reset is released, `in_ready` is high.
- R2: A source packet (kind 1) opens an event and produces no output. A later closing packet produces a record one cycle after it is accepted. The closing packet is either kind 2 (target) or kind 3 (target that also ends tracing). In that record `ev_src_valid`=1 and `ev_src` equals the source payload. `ev_dst_valid` equals `in_has_addr` of the closing packet. `ev_dst` is that packet's payload, or 0 when it carries no address. `ev_trace_off` is 1 only for kind 3.
- R3: Timing packets (kinds 7, 8, 9, 10) are forwarded one cycle later with `pass_kind` and `pass_data` equal to the input. The open event and its source address are left unchanged.
- R4: A state-change packet (kind 5 = address-space change, kind 6 = execution-mode change) that arrives inside an open event is not forwarded. It is held and reported in the closing record. `ev_upd_cnt` is the number held. Slot i of `ev_upd_data` (bits i*64 and up) holds the i-th payload in arrival order, and unused slots read 0. `ev_upd_mode` bit i is 1 when slot i came from kind 6. `ev_upd_mask` bit 0 is set when any kind 5 is held, and bit 1 when any kind 6 is held.
- R5: A branch-outcome packet (kind 4) is forwarded on the pass-through port one cycle later and has no effect on the open event.
- R6: A closing packet with no open event gives a record with `ev_src_valid`=0, `ev_src`=0, `ev_upd_cnt`=0 and `ev_upd_mask`=0.
- R7: A source packet that arrives while an event is open raises `err_valid` with `err_code` bit 0 set one cycle later. The pending event and its held updates are discarded, and a new event opens with the new source address.
- R8: At most 4 state changes are held per event. A further one inside the same event raises `err_valid` with `err_code` bit 1 set and is discarded, and the first 4 are kept.
- R9: A state-change packet that arrives while no event is open is forwarded on the pass-through port one cycle later.
- R10: After a record is emitted the event is closed, so an immediately following closing packet reports `ev_src_valid`=0.
- R11: Kind 0 and kinds 11 to 15 are ignored. They produce no output and do not change the open event or the held updates.
- R12: `pass_valid`, `ev_valid` and `err_valid` are single-cycle pulses. Each goes high only in the cycle after the packet that caused it, and all three are low in a cycle after no packet was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet present |
| in_ready | output | 1 | Block accepts a packet this cycle |
| in_kind | input | 4 | Decoded packet type |
| in_has_addr | input | 1 | Payload carries a valid address |
| in_addr | input | 64 | Packet payload |
| pass_valid | output | 1 | Forwarded packet pulse |
| pass_kind | output | 4 | Type of forwarded packet |
| pass_data | output | 64 | Payload of forwarded packet |
| ev_valid | output | 1 | Compound event record pulse |
| ev_src_valid | output | 1 | Source address is known |
| ev_src | output | 64 | Source address |
| ev_dst_valid | output | 1 | Destination address is known |
| ev_dst | output | 64 | Destination address |
| ev_trace_off | output | 1 | Event closed by a target-and-trace-off packet |
| ev_upd_mask | output | 2 | Bit 0: address-space change held; bit 1: mode change held |
| ev_upd_cnt | output | 3 | Number of held state changes |
| ev_upd_mode | output | 4 | Per slot: 1 = mode change, 0 = address-space change |
| ev_upd_data | output | 256 | Held payloads, slot i at bits i*64 and up |
| err_valid | output | 1 | Protocol error pulse |
| err_code | output | 2 | Bit 0: repeated source; bit 1: held-update overflow |

## Verification
The hardest case to reach is the overflow of the held-update buffer. It needs an event kept open across more state changes than there are slots. It also needs timing and branch packets interleaved, to show that they neither close the event nor use up slots. The bench covers this with a nested sweep. It varies the number of held updates from none to past the limit, the mix of update kinds, the number of interleaved timing packets and the closing kind. A model in the bench predicts each record slot by slot. Separate runs repeat the source packet after updates have been held, to confirm that they are dropped.

// File: rtl/trev_pkg.sv
package trev_pkg;

  typedef enum logic [3:0] {
    PK_NONE    = 4'd0,
    PK_SRC     = 4'd1,
    PK_TGT     = 4'd2,
    PK_TGT_OFF = 4'd3,
    PK_BR      = 4'd4,
    PK_ASPACE  = 4'd5,
    PK_XMODE   = 4'd6,
    PK_TSTAMP  = 4'd7,
    PK_MTICK   = 4'd8,
    PK_CYCLES  = 4'd9,
    PK_RATIO   = 4'd10
  } pkt_kind_e;

  typedef struct packed {
    logic is_src;
    logic is_close;
    logic is_off;
    logic is_timing;
    logic is_branch;
    logic is_state;
    logic is_mode;
  } pkt_class_t;

endpackage

// File: rtl/trev_classify.sv
module trev_classify
  import trev_pkg::*;
#(
  parameter int KW = 4
) (
  input  logic [KW-1:0] kind,
  output pkt_class_t    cls
);

  always_comb begin
    cls = '0;
    case (kind)
      PK_SRC:     cls.is_src    = 1'b1;
      PK_TGT:     cls.is_close  = 1'b1;
      PK_TGT_OFF: begin
        cls.is_close = 1'b1;
        cls.is_off   = 1'b1;
      end
      PK_BR:      cls.is_branch = 1'b1;
      PK_ASPACE:  cls.is_state  = 1'b1;
      PK_XMODE: begin
        cls.is_state = 1'b1;
        cls.is_mode  = 1'b1;
      end
      PK_TSTAMP, PK_MTICK, PK_CYCLES, PK_RATIO: cls.is_timing = 1'b1;
      default: cls = '0;
    endcase
  end

endmodule

// File: rtl/trev_pair_fsm.sv
module trev_pair_fsm #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_acc,
  input  logic          close_acc,
  input  logic [AW-1:0] src_addr,
  output logic          open_q,
  output logic [AW-1:0] src_q
);

  logic open_d;
  logic src_en;

  always_comb begin
    src_en = src_acc;
    open_d = open_q;
    if (src_acc)        open_d = 1'b1;
    else if (close_acc) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  always_ff @(posedge clk) begin
    if (src_en) src_q <= src_addr;
  end

  a_r2_open_after_src: assert property (@(posedge clk) disable iff (!rst_n)
    src_acc |=> open_q);

  a_r10_close_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (close_acc && !src_acc) |=> !open_q);

endmodule

// File: rtl/trev_hold_buf.sv
module trev_hold_buf #(
  parameter int AW    = 64,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                push_mode,
  input  logic [AW-1:0]       push_data,
  input  logic                clear,
  output logic                full,
  output logic [CW-1:0]       cnt_q,
  output logic [DEPTH-1:0]    mode_out,
  output logic [DEPTH*AW-1:0] data_out,
  output logic [1:0]          kind_mask
);

  logic [CW-1:0]    cnt_d;
  logic [AW-1:0]    slot_data [DEPTH];
  logic [DEPTH-1:0] slot_mode;
  logic [DEPTH-1:0] slot_used;

  assign full = (cnt_q == CW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (push) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && !clear && (cnt_q == CW'(i));

    always_ff @(posedge clk) begin
      if (wr_en) begin
        slot_data[i] <= push_data;
        slot_mode[i] <= push_mode;
      end
    end

    assign slot_used[i]            = (cnt_q > CW'(i));
    assign mode_out[i]             = slot_used[i] & slot_mode[i];
    assign data_out[i*AW +: AW]    = slot_used[i] ? slot_data[i] : '0;
  end

  assign kind_mask[0] = |(slot_used & ~slot_mode);
  assign kind_mask[1] = |(slot_used & slot_mode);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/trace_event_binder.sv
module trace_event_binder
  import trev_pkg::*;
#(
  parameter int AW    = 64,
  parameter int KW    = 4,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [KW-1:0]       in_kind,
  input  logic                in_has_addr,
  input  logic [AW-1:0]       in_addr,
  output logic                pass_valid,
  output logic [KW-1:0]       pass_kind,
  output logic [AW-1:0]       pass_data,
  output logic                ev_valid,
  output logic                ev_src_valid,
  output logic [AW-1:0]       ev_src,
  output logic                ev_dst_valid,
  output logic [AW-1:0]       ev_dst,
  output logic                ev_trace_off,
  output logic [1:0]          ev_upd_mask,
  output logic [CW-1:0]       ev_upd_cnt,
  output logic [DEPTH-1:0]    ev_upd_mode,
  output logic [DEPTH*AW-1:0] ev_upd_data,
  output logic                err_valid,
  output logic [1:0]          err_code
);

  pkt_class_t cls;
  logic       rdy_q;
  logic       acc;
  logic       open_q;
  logic [AW-1:0] src_q;

  logic pass_en, close_en, src_en, push_en, ovf_en, dup_en, clr_en, err_en;

  logic                buf_full;
  logic [CW-1:0]       buf_cnt;
  logic [DEPTH-1:0]    buf_mode;
  logic [DEPTH*AW-1:0] buf_data;
  logic [1:0]          buf_mask;

  trev_classify #(.KW(KW)) u_cls (
    .kind (in_kind),
    .cls  (cls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;

  always_comb begin
    acc      = in_valid && rdy_q;
    src_en   = acc && cls.is_src;
    close_en = acc && cls.is_close;
    dup_en   = src_en && open_q;
    push_en  = acc && cls.is_state && open_q && !buf_full;
    ovf_en   = acc && cls.is_state && open_q && buf_full;
    pass_en  = acc && (cls.is_timing || cls.is_branch || (cls.is_state && !open_q));
    clr_en   = close_en || src_en;
    err_en   = dup_en || ovf_en;
  end

  trev_pair_fsm #(.AW(AW)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_acc   (src_en),
    .close_acc (close_en),
    .src_addr  (in_addr),
    .open_q    (open_q),
    .src_q     (src_q)
  );

  trev_hold_buf #(.AW(AW), .DEPTH(DEPTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_en),
    .push_mode (cls.is_mode),
    .push_data (in_addr),
    .clear     (clr_en),
    .full      (buf_full),
    .cnt_q     (buf_cnt),
    .mode_out  (buf_mode),
    .data_out  (buf_data),
    .kind_mask (buf_mask)
  );

  // pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_valid <= 1'b0;
      ev_valid   <= 1'b0;
      err_valid  <= 1'b0;
    end else begin
      pass_valid <= pass_en;
      ev_valid   <= close_en;
      err_valid  <= err_en;
    end
  end

  // payload registers, enabled by their pulses
  always_ff @(posedge clk) begin
    if (pass_en) begin
      pass_kind <= in_kind;
      pass_data <= in_addr;
    end
    if (close_en) begin
      ev_src_valid <= open_q;
      ev_src       <= open_q ? src_q : '0;
      ev_dst_valid <= in_has_addr;
      ev_dst       <= in_has_addr ? in_addr : '0;
      ev_trace_off <= cls.is_off;
      ev_upd_mask  <= buf_mask;
      ev_upd_cnt   <= buf_cnt;
      ev_upd_mode  <= buf_mode;
      ev_upd_data  <= buf_data;
    end
    if (err_en) begin
      err_code <= {ovf_en, dup_en};
    end
  end

  a_r12_single_output: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_valid && ev_valid));

  a_r7_dup_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rdy_q && cls.is_src && open_q) |=> (err_valid && err_code[0]));

  a_r6_orphan_close: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rdy_q && cls.is_close && !open_q) |=> (ev_valid && !ev_src_valid));

  a_r10_closed_after_record: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !open_q);

  a_r4_held_not_passed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rdy_q && cls.is_state && open_q) |=> !pass_valid);

  a_r3_timing_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rdy_q && cls.is_timing && open_q) |=> (open_q && pass_valid));

endmodule

// File: tb/sim_trace_event_binder.sv
module sim_trace_event_binder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_kind = '0;
  logic in_has_addr = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic pass_valid;
  logic [3:0] pass_kind;
  logic [AW-1:0] pass_data;
  logic ev_valid, ev_src_valid, ev_dst_valid, ev_trace_off;
  logic [AW-1:0] ev_src, ev_dst;
  logic [1:0] ev_upd_mask;
  logic [2:0] ev_upd_cnt;
  logic [DEPTH-1:0] ev_upd_mode;
  logic [DEPTH*AW-1:0] ev_upd_data;
  logic err_valid;
  logic [1:0] err_code;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // reference model
  bit          m_open = 0;
  logic [63:0] m_src = '0;
  int          m_cnt = 0;
  logic [63:0] m_data [DEPTH];
  bit          m_mode [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_event_binder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_has_addr(in_has_addr), .in_addr(in_addr),
    .pass_valid(pass_valid), .pass_kind(pass_kind), .pass_data(pass_data),
    .ev_valid(ev_valid), .ev_src_valid(ev_src_valid), .ev_src(ev_src),
    .ev_dst_valid(ev_dst_valid), .ev_dst(ev_dst), .ev_trace_off(ev_trace_off),
    .ev_upd_mask(ev_upd_mask), .ev_upd_cnt(ev_upd_cnt), .ev_upd_mode(ev_upd_mode),
    .ev_upd_data(ev_upd_data), .err_valid(err_valid), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    @(negedge clk);
    chk(!pass_valid && !ev_valid && !err_valid, "R12", "valids after idle",
        {61'd0, pass_valid, ev_valid, err_valid}, 64'd0);
  endtask

  task automatic send(input logic [3:0] k, input bit h, input logic [63:0] a,
                      input string force_tag);
    bit e_pass = 0, e_ev = 0, e_err = 0;
    logic [1:0] e_code = '0;
    bit e_sv = 0, e_dv = 0, e_off = 0;
    logic [63:0] e_src = '0, e_dst = '0;
    int e_cnt = 0;
    logic [1:0] e_mask = '0;
    logic [DEPTH-1:0] e_mode = '0;
    logic [DEPTH*AW-1:0] e_data = '0;
    string tag = "R11";
    if (k == 4) begin e_pass = 1; tag = "R5"; end
    else if (k >= 7 && k <= 10) begin e_pass = 1; tag = "R3"; end
    else if (k == 5 || k == 6) begin
      if (!m_open) begin e_pass = 1; tag = "R9"; end
      else if (m_cnt < DEPTH) begin
        m_data[m_cnt] = a; m_mode[m_cnt] = (k == 6); m_cnt++; tag = "R4";
      end else begin e_err = 1; e_code = 2'b10; tag = "R8"; end
    end else if (k == 1) begin
      tag = "R2";
      if (m_open) begin e_err = 1; e_code = 2'b01; tag = "R7"; end
      m_open = 1; m_src = a; m_cnt = 0;
    end else if (k == 2 || k == 3) begin
      e_ev = 1; e_sv = m_open; e_src = m_open ? m_src : '0;
      e_dv = h; e_dst = h ? a : '0; e_off = (k == 3); e_cnt = m_cnt;
      for (int i = 0; i < DEPTH; i++) begin
        if (i < m_cnt) begin
          e_data[i*AW +: AW] = m_data[i];
          e_mode[i] = m_mode[i];
          if (m_mode[i]) e_mask[1] = 1'b1; else e_mask[0] = 1'b1;
        end
      end
      tag = m_open ? "R2" : "R6";
      m_open = 0; m_cnt = 0;
    end
    if (force_tag != "") tag = force_tag;
    in_valid = 1'b1; in_kind = k; in_has_addr = h; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(pass_valid == e_pass, tag, "pass_valid", 64'(pass_valid), 64'(e_pass));
    if (e_pass) begin
      chk(pass_kind == k, tag, "pass_kind", 64'(pass_kind), 64'(k));
      chk(pass_data == a, tag, "pass_data", pass_data, a);
    end
    chk(ev_valid == e_ev, tag, "ev_valid", 64'(ev_valid), 64'(e_ev));
    if (e_ev) begin
      chk(ev_src_valid == e_sv, tag, "ev_src_valid", 64'(ev_src_valid), 64'(e_sv));
      chk(ev_src == e_src, tag, "ev_src", ev_src, e_src);
      chk(ev_dst_valid == e_dv, tag, "ev_dst_valid", 64'(ev_dst_valid), 64'(e_dv));
      chk(ev_dst == e_dst, tag, "ev_dst", ev_dst, e_dst);
      chk(ev_trace_off == e_off, tag, "ev_trace_off", 64'(ev_trace_off), 64'(e_off));
      chk(int'(ev_upd_cnt) == e_cnt, tag, "ev_upd_cnt", 64'(ev_upd_cnt), 64'(e_cnt));
      chk(ev_upd_mask == e_mask, tag, "ev_upd_mask", 64'(ev_upd_mask), 64'(e_mask));
      chk(ev_upd_mode == e_mode, tag, "ev_upd_mode", 64'(ev_upd_mode), 64'(e_mode));
      for (int i = 0; i < DEPTH; i++)
        chk(ev_upd_data[i*AW +: AW] == e_data[i*AW +: AW], tag, "ev_upd_data slot",
            ev_upd_data[i*AW +: AW], e_data[i*AW +: AW]);
    end
    chk(err_valid == e_err, tag, "err_valid", 64'(err_valid), 64'(e_err));
    if (e_err) chk(err_code == e_code, tag, "err_code", 64'(err_code), 64'(e_code));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int scen = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!pass_valid && !ev_valid && !err_valid && !in_ready, "R1", "outputs in reset",
        {60'd0, in_ready, pass_valid, ev_valid, err_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    send(4'd2, 1'b1, 64'hD0, "R1");  // no event open after reset
    idle_check();

    // R2 R3 R4 R5 R8 R10: sweep update counts, kind mixes, timing interleave, close kind
    for (int nupd = 0; nupd <= DEPTH + 2; nupd++) begin
      for (int ntim = 0; ntim < 3; ntim++) begin
        for (int ck = 2; ck <= 3; ck++) begin
          for (int h = 0; h < 2; h++) begin
            int pat = nupd * 5 + ntim * 3 + ck + h;
            scen++;
            send(4'd1, 1'b1, 64'hA000_0000_0000_0000 + 64'(scen), "");
            for (int u = 0; u < nupd; u++) begin
              if (u < ntim) send(4'(7 + ((u + pat) % 4)), 1'b0, 64'h7000 + 64'(u), "");
              if (u == 1) send(4'd4, 1'b0, 64'h4444, "");
              send(((pat >> u) & 1) ? 4'd6 : 4'd5, 1'b1,
                   64'h5000_0000 + 64'(scen * 16 + u), "");
            end
            if (ntim == 2) send(4'd10, 1'b0, 64'hCB, "");
            send(4'(ck), 1'(h), 64'hB000_0000_0000_0000 + 64'(scen), "");
            send(4'd2, 1'b1, 64'hE000 + 64'(scen), "R10");
          end
        end
      end
    end
    idle_check();

    // R7: repeated source after held updates drops them
    for (int n = 0; n <= DEPTH; n++) begin
      send(4'd1, 1'b1, 64'h1111_0000 + 64'(n), "");
      for (int u = 0; u < n; u++) send(4'(5 + (u % 2)), 1'b1, 64'h2200 + 64'(u), "");
      send(4'd1, 1'b1, 64'h3333_0000 + 64'(n), "R7");
      send(4'd6, 1'b1, 64'h4400 + 64'(n), "");
      send(4'd3, 1'b0, 64'h0, "R7");
    end

    // R9 R11 R6: every kind with no event open
    for (int k = 0; k < 16; k++) begin
      if (k != 1) send(4'(k), 1'b1, 64'h9000 + 64'(k), "");
      idle_check();
    end

    // R11: ignored kinds inside an open event
    send(4'd1, 1'b1, 64'hF00D, "");
    send(4'd5, 1'b1, 64'h55, "");
    for (int k = 11; k < 16; k++) send(4'(k), 1'b1, 64'hBAD0 + 64'(k), "R11");
    send(4'd0, 1'b1, 64'hBAD0, "R11");
    send(4'd2, 1'b1, 64'hCAFE, "R11");
    idle_check();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule